// File: doc/BRIEF.md
# Destination Identifier Queue Bypass

This block connects a leading instruction stream to a trailing redundant stream. Every instruction that the leading stream commits leaves one record in an in-order queue. If the instruction does not need a redundant copy, the record names its architectural destination register. If it does need one, the record is marked for re-execution. Every instruction that the trailing stream fetches takes the oldest record.

A direct record skips decode. The block takes the oldest committed result from an external committed-value queue and writes it into the operand buffer slot named by the record. A re-execute record sends the trailing instruction to decode unchanged. Decode slots are therefore spent only on instructions that really run twice.

Back-pressure works as follows. The commit side is stalled when the queue is full and no record leaves that cycle. The trailing fetch is stalled when the queue is empty, or when the oldest record is direct and the committed-value queue has nothing to give.

Top module: `dqb_bypass`

## Requirements
- R1: While reset is held and in the first cycle after it, `obuf_we`, `dec_valid` and `vq_pop` are 0. `trl_stall` is 1 because the queue is empty. `cmt_stall` is 0.
- R2: Records reach the trailing side in the order they were committed. The n-th accepted trailing instruction uses the n-th accepted commit record.
- R3: With `DEPTH` records held and no record leaving in that cycle, `cmt_stall` is 1 and a presented commit is not stored.
- R4: When a trailing instruction is accepted against a direct record (record bit 5 = 1, bits 4:0 = destination), the next cycle shows `obuf_we`=1, `obuf_addr` = that destination and `obuf_wdata` = the `vq_data` presented in the accept cycle. `dec_valid` is 0 in that cycle.
- R5: When a trailing instruction is accepted against a re-execute record (bit 5 = 0), the next cycle shows `dec_valid`=1 and `dec_instr` = the accepted `trl_instr`. `obuf_we` is 0 in that cycle.
- R6: `vq_pop` is 1 exactly in the cycle a trailing instruction is accepted against a direct record, and never while `vq_empty` is 1.
- R7: While the queue is empty, `trl_stall` is 1 and no trailing instruction is accepted.
- R8: While the oldest record is direct and `vq_empty` is 1, `trl_stall` is 1 and neither queue is popped.
- R9: A push and a pop in the same cycle are both accepted, including when the queue is full. In that case `cmt_stall` stays 0.
- R10: An oldest record marked for re-execution is accepted even while `vq_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmt_valid | input | 1 | A leading instruction commits this cycle |
| cmt_redo | input | 1 | The committing instruction needs redundant execution |
| cmt_dest | input | 5 | Architectural destination of the committing instruction |
| cmt_stall | output | 1 | Commit not accepted this cycle |
| trl_valid | input | 1 | A trailing instruction is fetched this cycle |
| trl_instr | input | IW | Trailing instruction word |
| trl_stall | output | 1 | Trailing fetch not accepted this cycle |
| vq_empty | input | 1 | Committed-value queue has no entry |
| vq_data | input | DW | Oldest committed value |
| vq_pop | output | 1 | Consume the oldest committed value |
| obuf_we | output | 1 | Operand buffer write strobe |
| obuf_addr | output | 5 | Operand buffer slot |
| obuf_wdata | output | DW | Operand buffer write value |
| dec_valid | output | 1 | Instruction forwarded to decode |
| dec_instr | output | IW | Forwarded instruction word |

## Verification
The assertions rely on two things from the surroundings. First, `vq_data` must hold the oldest committed value whenever `vq_empty` is low. Second, a commit or trailing fetch that meets a stall must be treated as not taken, because only accepted handshakes move either queue. The stimulus follows both rules. A bench model of the committed-value queue drives `vq_data` from its own front entry and advances only on `vq_pop`. The bench model of the record queue moves only on handshakes that the stall outputs allowed. Directed phases fill the queue past full, push and pop together while full, and starve the value queue behind both direct and re-execute heads. Seeded random traffic then mixes all of these cases.

// File: rtl/dqb_pkg.sv
package dqb_pkg;
  localparam int unsigned ARCH_REG_W = 5;

  typedef struct packed {
    logic                  direct;
    logic [ARCH_REG_W-1:0] dest;
  } dq_entry_t;

  localparam int unsigned ENTRY_W = $bits(dq_entry_t);
endpackage

// File: rtl/dqb_fifo.sv
module dqb_fifo
  import dqb_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  dq_entry_t push_entry,
  input  logic      pop,
  output logic      empty,
  output logic      full,
  output dq_entry_t head_entry
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  dq_entry_t        slot_q [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty      = (count_q == '0);
  assign full       = (count_q == FULL_CNT);
  assign head_entry = slot_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({push, pop})
      2'b10:   count_d = count_q + CNT_W'(1);
      2'b01:   count_d = count_q - CNT_W'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[i] <= push_entry;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push == pop) |=> $stable(count_q));
endmodule

// File: rtl/dqb_steer.sv
module dqb_steer
  import dqb_pkg::*;
#(
  parameter int unsigned IW = 32,
  parameter int unsigned DW = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trl_valid,
  input  logic [IW-1:0]         trl_instr,
  input  logic                  q_empty,
  input  dq_entry_t             head_entry,
  input  logic                  vq_empty,
  input  logic [DW-1:0]         vq_data,
  output logic                  q_pop,
  output logic                  trl_stall,
  output logic                  vq_pop,
  output logic                  obuf_we,
  output logic [ARCH_REG_W-1:0] obuf_addr,
  output logic [DW-1:0]         obuf_wdata,
  output logic                  dec_valid,
  output logic [IW-1:0]         dec_instr
);
  logic                  blocked;
  logic                  take_direct, take_decode;
  logic                  we_d, dec_d;
  logic [ARCH_REG_W-1:0] addr_q;
  logic [DW-1:0]         wdata_q;
  logic [IW-1:0]         instr_q;
  logic                  we_q, dec_q;

  assign blocked     = q_empty || (head_entry.direct && vq_empty);
  assign trl_stall   = blocked;
  assign q_pop       = trl_valid && !blocked;
  assign take_direct = q_pop && head_entry.direct;
  assign take_decode = q_pop && !head_entry.direct;
  assign vq_pop      = take_direct;

  always_comb begin
    we_d  = take_direct;
    dec_d = take_decode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      we_q  <= we_d;
      dec_q <= dec_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_direct) begin
      addr_q  <= head_entry.dest;
      wdata_q <= vq_data;
    end
    if (take_decode) instr_q <= trl_instr;
  end

  assign obuf_we    = we_q;
  assign obuf_addr  = addr_q;
  assign obuf_wdata = wdata_q;
  assign dec_valid  = dec_q;
  assign dec_instr  = instr_q;

  assert_vq_pop_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vq_pop |-> !vq_empty);

  assert_stall_on_starved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && head_entry.direct && vq_empty) |-> (trl_stall && !vq_pop));

  assert_one_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(obuf_we && dec_valid));

  assert_write_follows_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    obuf_we |-> $past(vq_pop));
endmodule

// File: rtl/dqb_bypass.sv
module dqb_bypass
  import dqb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned IW    = 32,
  parameter int unsigned DW    = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmt_valid,
  input  logic                  cmt_redo,
  input  logic [ARCH_REG_W-1:0] cmt_dest,
  output logic                  cmt_stall,
  input  logic                  trl_valid,
  input  logic [IW-1:0]         trl_instr,
  output logic                  trl_stall,
  input  logic                  vq_empty,
  input  logic [DW-1:0]         vq_data,
  output logic                  vq_pop,
  output logic                  obuf_we,
  output logic [ARCH_REG_W-1:0] obuf_addr,
  output logic [DW-1:0]         obuf_wdata,
  output logic                  dec_valid,
  output logic [IW-1:0]         dec_instr
);
  logic      q_empty, q_full, q_pop, q_push;
  dq_entry_t new_entry, head_entry;

  always_comb begin
    new_entry.direct = !cmt_redo;
    new_entry.dest   = cmt_dest;
  end

  assign cmt_stall = q_full && !q_pop;
  assign q_push    = cmt_valid && !cmt_stall;

  dqb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (q_push),
    .push_entry (new_entry),
    .pop        (q_pop),
    .empty      (q_empty),
    .full       (q_full),
    .head_entry (head_entry)
  );

  dqb_steer #(.IW(IW), .DW(DW)) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .trl_valid  (trl_valid),
    .trl_instr  (trl_instr),
    .q_empty    (q_empty),
    .head_entry (head_entry),
    .vq_empty   (vq_empty),
    .vq_data    (vq_data),
    .q_pop      (q_pop),
    .trl_stall  (trl_stall),
    .vq_pop     (vq_pop),
    .obuf_we    (obuf_we),
    .obuf_addr  (obuf_addr),
    .obuf_wdata (obuf_wdata),
    .dec_valid  (dec_valid),
    .dec_instr  (dec_instr)
  );

  assert_full_push_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && q_pop) |-> !cmt_stall);

  assert_empty_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> (trl_stall && !vq_pop));
endmodule

// File: tb/dqb_bypass_tb.sv
module dqb_bypass_tb;
  localparam int DEPTH = 64;
  localparam int IW    = 32;
  localparam int DW    = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmt_valid, cmt_redo;
  logic [4:0]    cmt_dest;
  logic          cmt_stall;
  logic          trl_valid;
  logic [IW-1:0] trl_instr;
  logic          trl_stall;
  logic          vq_empty;
  logic [DW-1:0] vq_data;
  logic          vq_pop;
  logic          obuf_we;
  logic [4:0]    obuf_addr;
  logic [DW-1:0] obuf_wdata;
  logic          dec_valid;
  logic [IW-1:0] dec_instr;

  int checks = 0;
  int errors = 0;

  logic [5:0]    mq[$];
  logic [DW-1:0] vq[$];

  logic          exp_we = 1'b0, exp_dec = 1'b0;
  logic [4:0]    exp_addr;
  logic [DW-1:0] exp_wdata;
  logic [IW-1:0] exp_instr;

  always #10 clk = ~clk;

  dqb_bypass #(.DEPTH(DEPTH), .IW(IW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmt_valid(cmt_valid), .cmt_redo(cmt_redo), .cmt_dest(cmt_dest), .cmt_stall(cmt_stall),
    .trl_valid(trl_valid), .trl_instr(trl_instr), .trl_stall(trl_stall),
    .vq_empty(vq_empty), .vq_data(vq_data), .vq_pop(vq_pop),
    .obuf_we(obuf_we), .obuf_addr(obuf_addr), .obuf_wdata(obuf_wdata),
    .dec_valid(dec_valid), .dec_instr(dec_instr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_blocked(input bit q_emp, input bit hd_direct, input bit v_emp);
    return q_emp || (hd_direct && v_emp);
  endfunction

  task automatic cycle(input int cp, input int tp, input int vp, input int rp);
    bit q_emp, q_full, hd_direct, v_emp, pop, push;
    @(negedge clk);
    chk("R4 obuf_we", 64'(obuf_we), 64'(exp_we));
    if (exp_we) begin
      chk("R2 obuf_addr order", 64'(obuf_addr), 64'(exp_addr));
      chk("R4 obuf_wdata", obuf_wdata, exp_wdata);
    end
    chk("R5 dec_valid", 64'(dec_valid), 64'(exp_dec));
    if (exp_dec) chk("R5 dec_instr", 64'(dec_instr), 64'(exp_instr));

    if ($urandom_range(99) < vp) vq.push_back({$urandom, $urandom});
    cmt_valid = ($urandom_range(99) < cp);
    cmt_redo  = ($urandom_range(99) < rp);
    cmt_dest  = 5'($urandom);
    trl_valid = ($urandom_range(99) < tp);
    trl_instr = $urandom;
    vq_empty  = (vq.size() == 0);
    vq_data   = vq_empty ? '0 : vq[0];
    #1;
    q_emp     = (mq.size() == 0);
    q_full    = (mq.size() == DEPTH);
    hd_direct = !q_emp && mq[0][5];
    v_emp     = (vq.size() == 0);
    pop       = trl_valid && !exp_blocked(q_emp, hd_direct, v_emp);
    push      = cmt_valid && !(q_full && !pop);

    if (q_full && pop) chk("R9 cmt_stall full with pop", 64'(cmt_stall), 64'(0));
    else               chk("R3 cmt_stall", 64'(cmt_stall), 64'(q_full && !pop));
    if (q_emp)                  chk("R7 trl_stall empty", 64'(trl_stall), 64'(1));
    else if (hd_direct && v_emp) chk("R8 trl_stall starved", 64'(trl_stall), 64'(1));
    else                         chk("R10 trl_stall ready", 64'(trl_stall), 64'(0));
    chk("R6 vq_pop", 64'(vq_pop), 64'(pop && hd_direct));

    exp_we  = pop && hd_direct;
    exp_dec = pop && !hd_direct;
    if (exp_we) begin
      exp_addr  = mq[0][4:0];
      exp_wdata = vq[0];
    end
    if (exp_dec) exp_instr = trl_instr;
    if (pop) begin
      void'(mq.pop_front());
      if (hd_direct) void'(vq.pop_front());
    end
    if (push) mq.push_back({!cmt_redo, cmt_dest});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    cmt_valid = 1'b0; cmt_redo = 1'b0; cmt_dest = '0;
    trl_valid = 1'b0; trl_instr = '0;
    vq_empty = 1'b1; vq_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset obuf_we", 64'(obuf_we), 64'(0));
    chk("R1 reset dec_valid", 64'(dec_valid), 64'(0));
    chk("R1 reset trl_stall", 64'(trl_stall), 64'(1));
    chk("R1 reset cmt_stall", 64'(cmt_stall), 64'(0));
    chk("R1 reset vq_pop", 64'(vq_pop), 64'(0));
    rst_n = 1'b1;

    // R3: fill past full with no pops
    repeat (DEPTH + 6) cycle(100, 0, 0, 50);
    // R9: push and pop together while full
    repeat (12) cycle(100, 100, 100, 50);
    // R8/R10: value queue starved, re-execute heads still drain
    repeat (80) cycle(0, 100, 0, 0);
    // R7: drain to empty and keep fetching
    repeat (DEPTH + 40) cycle(0, 100, 100, 0);
    // mixed random traffic
    repeat (4000) cycle(60, 55, 50, 40);
    repeat (1000) cycle(90, 30, 70, 20);
    repeat (1000) cycle(30, 90, 40, 60);
    repeat (2) cycle(0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule